// File: doc/BRIEF.md
# Two-Wire Memory Transaction Sequencer

This block runs complete memory-style transactions on a two-wire (I2C) bus by issuing byte-level commands to a separate bit engine. The bit engine handles all timing. The sequencer decides the order of START, STOP, byte-write and byte-read commands and reacts to the acknowledge bit that each byte returns. Three operations are supported: a presence probe, a random read and a sequential write. The register address sent to the device is 0 to 3 bytes long, and the length is chosen per transaction.

A transaction begins with a one-cycle `go` pulse while the block is idle. All inputs are latched on that pulse. Write payload bytes are pulled from a byte-wide valid/ready stream, and read bytes are pushed out on a second one. Back-pressure rules apply to both streams:
- A write byte is consumed only in a cycle where `wr_valid` and `wr_ready` are both high.
- Once `rd_valid` rises, it stays high and `rd_data` holds its value until `rd_ready` is seen. No further bus command is issued meanwhile.
- The command port follows the same rule: a command stays stable until `cmd_ready` accepts it.

After a command is accepted, the sequencer waits for one `rsp_valid` pulse before it issues the next command. When the transaction ends, `busy` falls, and at that point `err_code` and `fail_cnt` are valid.

Top module: `i2c_mem_seq`

## Requirements
- R1: Probe (op 0) issues START, a write of {dev,0}, then STOP. `err_code` ends 0 if that byte was ACKed and 1 if it was NACKed.
- R2: The register-address bytes are sent most significant byte first. Their number equals `addr_len`, and none are sent when `addr_len` is 0.
- R3: A read (op 1) with `addr_len` 0 issues START and then the write of {dev,1} directly, with no addressing phase.
- R4: A read with `addr_len` > 0 sends START, {dev,0} and the address bytes. It then sends STOP followed by START when `restart_mode` is 0, or START alone when it is 1. After that it sends {dev,1}.
- R5: In a read, every read command requests ACK except the last one, which requests NACK (`cmd_nack`=1). A STOP follows. The bytes appear on the read stream in bus order.
- R6: A NACK on either device-address byte ({dev,0} or {dev,1}) is followed by STOP and ends with `err_code` 1.
- R7: A NACK on any register-address byte is followed by STOP, and `err_code` ends 2.
- R8: In a write (op 2), a NACK on a data byte does not abort the transaction. Each such NACK adds 1 to `fail_cnt`, all bytes are still sent, then STOP follows. `err_code` is 0.
- R9: When `fold_en` is 1, the address bits above the 8*`addr_len` sent bits are masked with `fold_mask` and ORed into the device address. When `fold_en` is 0, the device address is used unchanged.
- R10: A write with `byte_cnt` 0 sends only the addressing phase and then STOP.
- R11: A read with `byte_cnt` 0, or op 3, issues no bus command and ends with `err_code` 3.
- R12: A command stays stable until it is accepted. `rd_data` holds its value while `rd_valid` waits for `rd_ready`.
- R13: `busy` rises the cycle after an accepted `go` and stays low while idle. While idle, no command is offered and neither stream is active. Error codes: 0 ok, 1 no device, 2 address NACK, 3 bad parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, taken while idle |
| op | input | 2 | 0 probe, 1 read, 2 write, 3 invalid |
| dev_addr | input | 7 | 7-bit device address |
| reg_addr | input | 8*ADDR_BYTES | Register address, low bytes sent |
| addr_len | input | 2 | Register address bytes, 0..ADDR_BYTES |
| byte_cnt | input | BCW | Data bytes to move |
| restart_mode | input | 1 | 1: repeated START, 0: STOP then START |
| fold_en | input | 1 | Fold upper address bits into device address |
| fold_mask | input | 7 | Mask for folded bits |
| cmd_valid | output | 1 | Command offered to bit engine |
| cmd_ready | input | 1 | Bit engine accepts command |
| cmd_code | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmd_wdata | output | 8 | Byte to write (0 otherwise) |
| cmd_nack | output | 1 | For read: 1 sends NACK after the byte |
| rsp_valid | input | 1 | Command completed pulse |
| rsp_nack | input | 1 | Written byte was not acknowledged |
| rsp_rdata | input | 8 | Byte read from bus |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Sequencer takes a write byte |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read stream byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read stream byte |
| busy | output | 1 | Transaction in progress |
| err_code | output | 2 | Result, valid when busy falls |
| fail_cnt | output | BCW | NACKed data bytes in last write |

## Verification
A wrong state in this sequencer shows up in the command log of the bit engine within one command. A command could be skipped, repeated or out of order, the address bytes could be in the wrong order, or the ACK/NACK request on a read byte could be wrong. Each of these differs from the expected sequence at the first such command. A wrong error path shows up when `busy` falls: either `err_code` differs or the closing STOP is missing. A counting fault in the remaining-byte or failure logic shows up as a wrong read-stream byte count or a wrong `fail_cnt` at the end of the same transaction. Holding a stream stalled exposes any loss of the held byte within the stall itself.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam logic [1:0] CMD_START = 2'd0;
  localparam logic [1:0] CMD_STOP  = 2'd1;
  localparam logic [1:0] CMD_WRITE = 2'd2;
  localparam logic [1:0] CMD_READ  = 2'd3;

  localparam logic [1:0] OP_PROBE  = 2'd0;
  localparam logic [1:0] OP_READ   = 2'd1;
  localparam logic [1:0] OP_WRITE  = 2'd2;

  localparam logic [1:0] ERR_OK    = 2'd0;
  localparam logic [1:0] ERR_NODEV = 2'd1;
  localparam logic [1:0] ERR_ADDR  = 2'd2;
  localparam logic [1:0] ERR_PARAM = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_DEVW, ST_REGA, ST_MIDSTOP, ST_RESTART,
    ST_DEVR, ST_RDATA, ST_RPUSH, ST_WFETCH, ST_WDATA, ST_STOP, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/i2c_seq_fold.sv
module i2c_seq_fold #(
  parameter int ADDR_BYTES = 3,
  localparam int AW  = 8 * ADDR_BYTES,
  localparam int ALW = $clog2(ADDR_BYTES + 1)
) (
  input  logic [6:0]     dev_in,
  input  logic [AW-1:0]  addr_in,
  input  logic [ALW-1:0] len_in,
  input  logic           fold_on,
  input  logic [6:0]     mask_in,
  output logic [6:0]     dev_out
);
  logic [AW-1:0] upper;

  // Bits above the transmitted address bytes
  always_comb begin
    upper = '0;
    for (int i = 0; i <= ADDR_BYTES; i++) begin
      if (len_in == ALW'(i)) upper = addr_in >> (8 * i);
    end
  end

  assign dev_out = fold_on ? (dev_in | (upper[6:0] & mask_in)) : dev_in;
endmodule

// File: rtl/i2c_seq_failcnt.sv
module i2c_seq_failcnt #(
  parameter int BCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           inc,
  output logic [BCW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && cnt != '1)    cnt <= cnt + BCW'(1);
  end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int BCW = 8,
  localparam int AW  = 8 * ADDR_BYTES,
  localparam int ALW = $clog2(ADDR_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [1:0]     op,
  input  logic [6:0]     dev_eff,
  input  logic [AW-1:0]  reg_addr,
  input  logic [ALW-1:0] addr_len,
  input  logic [BCW-1:0] byte_cnt,
  input  logic           restart_mode,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [1:0]     cmd_code,
  output logic [7:0]     cmd_wdata,
  output logic           cmd_nack,
  input  logic           rsp_valid,
  input  logic           rsp_nack,
  input  logic [7:0]     rsp_rdata,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [7:0]     wr_data,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [7:0]     rd_data,
  output logic           busy,
  output logic [1:0]     err_code,
  output logic           fail_clr,
  output logic           fail_inc
);
  seq_state_e     st;
  logic           wait_q;
  logic [1:0]     op_q;
  logic [6:0]     dev_q;
  logic [AW-1:0]  addr_q;
  logic [ALW-1:0] alen_q;
  logic [ALW-1:0] idx_q;
  logic [BCW-1:0] left_q;
  logic           rsm_q;
  logic [7:0]     byte_q;
  logic [1:0]     err_q;
  logic           is_cmd;
  logic           done_rsp;
  logic           bad_req;
  logic           last_byte;

  assign bad_req   = (op == 2'd3) || (op == OP_READ && byte_cnt == '0);
  assign last_byte = (left_q == BCW'(1));

  always_comb begin
    is_cmd    = 1'b1;
    cmd_code  = CMD_START;
    cmd_wdata = 8'h00;
    cmd_nack  = 1'b0;
    case (st)
      ST_START, ST_RESTART: cmd_code = CMD_START;
      ST_MIDSTOP, ST_STOP:  cmd_code = CMD_STOP;
      ST_DEVW: begin cmd_code = CMD_WRITE; cmd_wdata = {dev_q, 1'b0}; end
      ST_DEVR: begin cmd_code = CMD_WRITE; cmd_wdata = {dev_q, 1'b1}; end
      ST_REGA: begin cmd_code = CMD_WRITE; cmd_wdata = addr_q[idx_q*8 +: 8]; end
      ST_WDATA: begin cmd_code = CMD_WRITE; cmd_wdata = byte_q; end
      ST_RDATA: begin cmd_code = CMD_READ; cmd_nack = last_byte; end
      default: is_cmd = 1'b0;
    endcase
  end

  assign cmd_valid = is_cmd && !wait_q;
  assign done_rsp  = is_cmd && wait_q && rsp_valid;
  assign wr_ready  = (st == ST_WFETCH);
  assign rd_valid  = (st == ST_RPUSH);
  assign rd_data   = byte_q;
  assign busy      = (st != ST_IDLE);
  assign err_code  = err_q;
  assign fail_clr  = (st == ST_IDLE) && go;
  assign fail_inc  = (st == ST_WDATA) && done_rsp && rsp_nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      wait_q <= 1'b0;
      op_q   <= OP_PROBE;
      dev_q  <= '0;
      addr_q <= '0;
      alen_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
      rsm_q  <= 1'b0;
      byte_q <= '0;
      err_q  <= ERR_OK;
    end else begin
      if (cmd_valid && cmd_ready) wait_q <= 1'b1;
      if (done_rsp)               wait_q <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          op_q   <= op;
          dev_q  <= dev_eff;
          addr_q <= reg_addr;
          alen_q <= addr_len;
          left_q <= byte_cnt;
          rsm_q  <= restart_mode;
          if (bad_req) begin
            err_q <= ERR_PARAM;
            st    <= ST_DONE;
          end else begin
            err_q <= ERR_OK;
            st    <= ST_START;
          end
        end
        ST_START: if (done_rsp)
          st <= (op_q == OP_READ && alen_q == '0) ? ST_DEVR : ST_DEVW;
        ST_DEVW: if (done_rsp) begin
          if (rsp_nack) begin
            err_q <= ERR_NODEV;
            st    <= ST_STOP;
          end else if (op_q == OP_PROBE) begin
            st <= ST_STOP;
          end else if (alen_q != '0) begin
            idx_q <= alen_q - ALW'(1);
            st    <= ST_REGA;
          end else begin
            st <= (left_q == '0) ? ST_STOP : ST_WFETCH;
          end
        end
        ST_REGA: if (done_rsp) begin
          if (rsp_nack) begin
            err_q <= ERR_ADDR;
            st    <= ST_STOP;
          end else if (idx_q != '0) begin
            idx_q <= idx_q - ALW'(1);
          end else if (op_q == OP_READ) begin
            st <= rsm_q ? ST_RESTART : ST_MIDSTOP;
          end else begin
            st <= (left_q == '0) ? ST_STOP : ST_WFETCH;
          end
        end
        ST_MIDSTOP: if (done_rsp) st <= ST_RESTART;
        ST_RESTART: if (done_rsp) st <= ST_DEVR;
        ST_DEVR: if (done_rsp) begin
          if (rsp_nack) begin
            err_q <= ERR_NODEV;
            st    <= ST_STOP;
          end else begin
            st <= ST_RDATA;
          end
        end
        ST_RDATA: if (done_rsp) begin
          byte_q <= rsp_rdata;
          st     <= ST_RPUSH;
        end
        ST_RPUSH: if (rd_ready) begin
          left_q <= left_q - BCW'(1);
          st     <= last_byte ? ST_STOP : ST_RDATA;
        end
        ST_WFETCH: if (wr_valid) begin
          byte_q <= wr_data;
          st     <= ST_WDATA;
        end
        ST_WDATA: if (done_rsp) begin
          left_q <= left_q - BCW'(1);
          st     <= last_byte ? ST_STOP : ST_WFETCH;
        end
        ST_STOP: if (done_rsp) st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq #(
  parameter int ADDR_BYTES = 3,
  parameter int BCW = 8,
  localparam int AW  = 8 * ADDR_BYTES,
  localparam int ALW = $clog2(ADDR_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [1:0]     op,
  input  logic [6:0]     dev_addr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [ALW-1:0] addr_len,
  input  logic [BCW-1:0] byte_cnt,
  input  logic           restart_mode,
  input  logic           fold_en,
  input  logic [6:0]     fold_mask,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [1:0]     cmd_code,
  output logic [7:0]     cmd_wdata,
  output logic           cmd_nack,
  input  logic           rsp_valid,
  input  logic           rsp_nack,
  input  logic [7:0]     rsp_rdata,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [7:0]     wr_data,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [7:0]     rd_data,
  output logic           busy,
  output logic [1:0]     err_code,
  output logic [BCW-1:0] fail_cnt
);
  logic [6:0] dev_eff;
  logic       fail_clr;
  logic       fail_inc;

  i2c_seq_fold #(.ADDR_BYTES(ADDR_BYTES)) u_fold (
    .dev_in  (dev_addr),
    .addr_in (reg_addr),
    .len_in  (addr_len),
    .fold_on (fold_en),
    .mask_in (fold_mask),
    .dev_out (dev_eff)
  );

  i2c_seq_ctrl #(.ADDR_BYTES(ADDR_BYTES), .BCW(BCW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .op           (op),
    .dev_eff      (dev_eff),
    .reg_addr     (reg_addr),
    .addr_len     (addr_len),
    .byte_cnt     (byte_cnt),
    .restart_mode (restart_mode),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_code     (cmd_code),
    .cmd_wdata    (cmd_wdata),
    .cmd_nack     (cmd_nack),
    .rsp_valid    (rsp_valid),
    .rsp_nack     (rsp_nack),
    .rsp_rdata    (rsp_rdata),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_data      (rd_data),
    .busy         (busy),
    .err_code     (err_code),
    .fail_clr     (fail_clr),
    .fail_inc     (fail_inc)
  );

  i2c_seq_failcnt #(.BCW(BCW)) u_fail (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fail_clr),
    .inc   (fail_inc),
    .cnt   (fail_cnt)
  );
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk #(
  parameter int BCW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           go,
  input logic [1:0]     op,
  input logic [BCW-1:0] byte_cnt,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [1:0]     cmd_code,
  input logic [7:0]     cmd_wdata,
  input logic           cmd_nack,
  input logic           wr_ready,
  input logic           rd_valid,
  input logic           rd_ready,
  input logic [7:0]     rd_data,
  input logic           busy,
  input logic [1:0]     err_code,
  input logic [BCW-1:0] fail_cnt
);
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_wdata) && $stable(cmd_nack));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !wr_ready && !rd_valid);

  p_go_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && go |=> busy);

  p_param_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && go && (op == 2'd3 || (op == 2'd1 && byte_cnt == '0)) |=> !cmd_valid && err_code == 2'd3);

  p_fail_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> fail_cnt >= $past(fail_cnt));
endmodule

bind i2c_mem_seq i2c_seq_chk #(.BCW(BCW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .op        (op),
  .byte_cnt  (byte_cnt),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_code  (cmd_code),
  .cmd_wdata (cmd_wdata),
  .cmd_nack  (cmd_nack),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .busy      (busy),
  .err_code  (err_code),
  .fail_cnt  (fail_cnt)
);

// File: tb/tb_i2c_mem_seq.sv
`timescale 1ns/1ps
module tb_i2c_mem_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [1:0]  op = '0;
  logic [6:0]  dev_addr = '0;
  logic [23:0] reg_addr = '0;
  logic [1:0]  addr_len = '0;
  logic [7:0]  byte_cnt = '0;
  logic        restart_mode = 1'b0;
  logic        fold_en = 1'b0;
  logic [6:0]  fold_mask = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [1:0]  cmd_code;
  logic [7:0]  cmd_wdata;
  logic        cmd_nack;
  logic        rsp_valid = 1'b0;
  logic        rsp_nack = 1'b0;
  logic [7:0]  rsp_rdata = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        busy;
  logic [1:0]  err_code;
  logic [7:0]  fail_cnt;

  always #2.5 clk = ~clk;

  i2c_mem_seq dut (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .dev_addr(dev_addr),
    .reg_addr(reg_addr), .addr_len(addr_len), .byte_cnt(byte_cnt),
    .restart_mode(restart_mode), .fold_en(fold_en), .fold_mask(fold_mask),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .rsp_rdata(rsp_rdata), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .busy(busy),
    .err_code(err_code), .fail_cnt(fail_cnt)
  );

  // Bus engine model: logs commands, answers two cycles after acceptance
  logic        clr = 1'b0;
  logic [15:0] nmask = '0;
  logic        rd_block = 1'b0;
  logic [9:0]  log_q [64];
  logic [7:0]  rd_got [64];
  int          log_n = 0, wi = 0, rsrc = 0, wk = 0, rk = 0;
  logic [1:0]  pend = '0;
  logic        pn = 1'b0;
  logic [7:0]  pd = '0;
  logic [7:0]  tick = '0;

  assign wr_data = 8'h50 + 8'(wk);

  always @(posedge clk) begin
    tick      <= tick + 8'd1;
    cmd_ready <= ~cmd_ready;
    rd_ready  <= !rd_block && tick[1];
    rsp_valid <= 1'b0;
    if (pend == 2'd1) begin
      rsp_valid <= 1'b1;
      rsp_nack  <= pn;
      rsp_rdata <= pd;
    end
    if (pend != 2'd0) pend <= pend - 2'd1;
    if (clr) begin
      log_n <= 0; wi <= 0; rsrc <= 0; wk <= 0; rk <= 0;
      wr_valid <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        if (log_n < 64)
          log_q[log_n] <= {cmd_code, (cmd_code == 2'd2) ? cmd_wdata :
                                     (cmd_code == 2'd3) ? {7'd0, cmd_nack} : 8'h00};
        log_n <= log_n + 1;
        pend  <= 2'd2;
        pn    <= 1'b0;
        pd    <= 8'h00;
        if (cmd_code == 2'd2) begin pn <= nmask[wi[3:0]]; wi <= wi + 1; end
        if (cmd_code == 2'd3) begin pd <= 8'hA0 + 8'(rsrc); rsrc <= rsrc + 1; end
      end
      if (wr_valid && wr_ready) begin
        wk <= wk + 1;
        wr_valid <= 1'b0;
      end else if (!wr_valid) begin
        wr_valid <= tick[1];
      end
      if (rd_valid && rd_ready) begin
        if (rk < 64) rd_got[rk] <= rd_data;
        rk <= rk + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input int rq, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  dev;
    logic [23:0] addr;
    logic [1:0]  alen;
    logic [7:0]  cnt;
    logic        rsm;
    logic        fen;
    logic [6:0]  fmask;
    logic [15:0] nm;
    logic [1:0]  eerr;
    logic [7:0]  efail;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{2'd0, 7'h50, 24'h000000, 2'd0, 8'd0, 1'b0, 1'b0, 7'h00, 16'h0000, 2'd0, 8'd0, 4'd1},  // R1 probe ack
    '{2'd0, 7'h51, 24'h000000, 2'd0, 8'd0, 1'b0, 1'b0, 7'h00, 16'h0001, 2'd1, 8'd0, 4'd1},  // R1 probe nack
    '{2'd2, 7'h50, 24'h001234, 2'd2, 8'd3, 1'b0, 1'b0, 7'h00, 16'h0000, 2'd0, 8'd0, 4'd2},  // R2 write
    '{2'd2, 7'h50, 24'h000077, 2'd1, 8'd4, 1'b0, 1'b0, 7'h00, 16'h0028, 2'd0, 8'd2, 4'd8},  // R8 data nacks
    '{2'd2, 7'h52, 24'h000010, 2'd1, 8'd2, 1'b0, 1'b0, 7'h00, 16'h0001, 2'd1, 8'd0, 4'd6},  // R6 dev nack
    '{2'd2, 7'h50, 24'hABCDEF, 2'd3, 8'd2, 1'b0, 1'b0, 7'h00, 16'h0004, 2'd2, 8'd0, 4'd7},  // R7 addr nack
    '{2'd2, 7'h50, 24'h000203, 2'd2, 8'd0, 1'b0, 1'b0, 7'h00, 16'h0000, 2'd0, 8'd0, 4'd10}, // R10 empty write
    '{2'd1, 7'h50, 24'h000000, 2'd0, 8'd2, 1'b0, 1'b0, 7'h00, 16'h0000, 2'd0, 8'd0, 4'd3},  // R3 direct read
    '{2'd1, 7'h50, 24'h000100, 2'd2, 8'd3, 1'b0, 1'b0, 7'h00, 16'h0000, 2'd0, 8'd0, 4'd4},  // R4 stop-start, R5
    '{2'd1, 7'h50, 24'h000005, 2'd1, 8'd1, 1'b1, 1'b0, 7'h00, 16'h0000, 2'd0, 8'd0, 4'd4},  // R4 repeated start
    '{2'd1, 7'h50, 24'h0003A5, 2'd1, 8'd2, 1'b0, 1'b1, 7'h07, 16'h0000, 2'd0, 8'd0, 4'd9},  // R9 fold on
    '{2'd1, 7'h50, 24'h000010, 2'd1, 8'd0, 1'b0, 1'b0, 7'h00, 16'h0000, 2'd3, 8'd0, 4'd11}, // R11 read cnt 0
    '{2'd3, 7'h50, 24'h000010, 2'd1, 8'd1, 1'b0, 1'b0, 7'h00, 16'h0000, 2'd3, 8'd0, 4'd11}, // R11 bad op
    '{2'd1, 7'h50, 24'h000000, 2'd0, 8'd1, 1'b0, 1'b0, 7'h00, 16'h0001, 2'd1, 8'd0, 4'd6},  // R6 read dev nack
    '{2'd2, 7'h50, 24'h0003A5, 2'd1, 8'd1, 1'b0, 1'b0, 7'h07, 16'h0000, 2'd0, 8'd0, 4'd9}   // R9 fold off
  };

  logic [9:0] ex [64];
  int         en;
  int         mwi;

  task automatic push(input logic [1:0] c, input logic [7:0] b);
    if (en < 64) ex[en] = {c, b};
    en++;
  endtask

  // Expected command sequence from the requirements
  task automatic build_exp(input vec_t v);
    logic [6:0]  d;
    logic [23:0] up;
    logic        ok;
    en = 0; mwi = 0; ok = 1'b1;
    up = v.addr >> (8 * int'(v.alen));
    d  = v.fen ? (v.dev | (up[6:0] & v.fmask)) : v.dev;
    if (v.op == 2'd3 || (v.op == 2'd1 && v.cnt == 0)) return;
    push(2'd0, 8'h00);
    if (v.op == 2'd0) begin
      push(2'd2, {d, 1'b0}); mwi++;
    end else begin
      if (v.op == 2'd2 || v.alen != 0) begin
        push(2'd2, {d, 1'b0}); if (v.nm[mwi]) ok = 1'b0; mwi++;
        for (int b = int'(v.alen) - 1; b >= 0; b--) begin
          if (ok) begin
            push(2'd2, v.addr[b*8 +: 8]); if (v.nm[mwi]) ok = 1'b0; mwi++;
          end
        end
        if (ok && v.op == 2'd1) begin
          if (!v.rsm) push(2'd1, 8'h00);
          push(2'd0, 8'h00);
        end
      end
      if (ok && v.op == 2'd2)
        for (int k = 0; k < int'(v.cnt); k++) push(2'd2, 8'h50 + 8'(k));
      if (ok && v.op == 2'd1) begin
        push(2'd2, {d, 1'b1}); if (v.nm[mwi]) ok = 1'b0; mwi++;
        if (ok) for (int k = 0; k < int'(v.cnt); k++) push(2'd3, {7'd0, k == int'(v.cnt) - 1});
      end
    end
    push(2'd1, 8'h00);
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    clr = 1'b1; nmask = v.nm;
    @(negedge clk);
    clr = 1'b0;
    op = v.op; dev_addr = v.dev; reg_addr = v.addr; addr_len = v.alen;
    byte_cnt = v.cnt; restart_mode = v.rsm; fold_en = v.fen; fold_mask = v.fmask;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(13, int'(busy), 1, "busy after go");
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic run_vec(input int i);
    vec_t v = VT[i];
    int   bad;
    launch(v);
    wait_idle();
    @(negedge clk);
    build_exp(v);
    chk(int'(v.rq), int'(err_code), int'(v.eerr), $sformatf("vec %0d err_code", i));
    chk(int'(v.rq), int'(fail_cnt), int'(v.efail), $sformatf("vec %0d fail_cnt", i));
    chk(int'(v.rq), log_n, en, $sformatf("vec %0d command count", i));
    bad = -1;
    for (int k = 0; k < en && k < log_n && k < 64; k++)
      if (bad < 0 && log_q[k] != ex[k]) bad = k;
    if (bad >= 0) chk(int'(v.rq), int'(log_q[bad]), int'(ex[bad]), $sformatf("vec %0d cmd %0d", i, bad));
    else          chk(int'(v.rq), 0, 0, $sformatf("vec %0d sequence", i));
    if (v.op == 2'd1 && v.eerr == 2'd0) begin
      chk(5, rk, int'(v.cnt), $sformatf("vec %0d read bytes", i));
      for (int k = 0; k < int'(v.cnt) && k < rk; k++)
        chk(5, int'(rd_got[k]), int'(8'hA0 + 8'(k)), $sformatf("vec %0d read byte %0d", i, k));
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(13, int'(busy), 0, "busy at reset");
    chk(13, int'(err_code), 0, "err at reset");
    chk(13, int'(cmd_valid), 0, "cmd_valid at reset");
    chk(12, int'(rd_valid), 0, "rd_valid at reset");

    for (int i = 0; i < NV; i++) run_vec(i);

    // R12: stalled read stream keeps its byte
    begin
      vec_t v = '{2'd1, 7'h50, 24'h0, 2'd0, 8'd1, 1'b0, 1'b0, 7'h00, 16'h0, 2'd0, 8'd0, 4'd12};
      int t = 0;
      rd_block = 1'b1;
      launch(v);
      while (!rd_valid && t < 2000) begin @(negedge clk); t++; end
      repeat (30) @(negedge clk);
      chk(12, int'(rd_valid), 1, "rd_valid held under stall");
      chk(12, int'(rd_data), 8'hA0, "rd_data held under stall");
      chk(12, int'(busy), 1, "busy during stall");
      rd_block = 1'b0;
      wait_idle();
      @(negedge clk);
      chk(12, rk, 1, "byte taken after release");
      chk(12, int'(err_code), 0, "err after stall");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule